// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a 32-bit RISC core that uses overlapping register windows. Each instruction names registers with a 5-bit architectural number. The block turns that number into a physical register index using a rotating current window pointer (CWP). Eight global registers are visible from every window. Each window also sees eight private locals, eight ins and eight outs. The outs of one window are the same physical registers as the ins of the next window down, so a caller passes arguments to a callee without copying any data.

The block has two combinational read ports and one write port. The write port commits at the clock edge. Save and restore commands move the pointer down and up, modulo the window count. A window invalid mask marks windows whose contents have been spilled or are reserved. A save or restore that would land on a marked window is refused, and the block raises an overflow or underflow trap request instead. Trap entry moves the pointer down without checking the mask. A privileged port loads the pointer and the mask directly. Spilling windows to memory and the trap handlers belong to software.

Top module: `wrf_top`

## Requirements
- R1: Architectural numbers 0-7 select globals, which are shared by every window. Numbers 8-15 select outs, 16-23 select locals and 24-31 select ins. The locals and ins of each window are private to that window.
- R2: Register 0 always reads as zero on both read ports. A write to register 0 is discarded.
- R3: A save that is not refused moves the pointer to (CWP-1) mod NWIN at the next clock edge. The step from 0 wraps to NWIN-1.
- R4: A restore that is not refused moves the pointer to (CWP+1) mod NWIN at the next clock edge. The step from NWIN-1 wraps to 0.
- R5: When a save targets a window whose mask bit is 1 (1 = invalid, 0 = valid), ovf_req_o is high in the same cycle as the save.
- R6: When a restore targets a window whose mask bit is 1, unf_req_o is high in the same cycle as the restore. At most one of the two requests is high at any time.
- R7: In a cycle that raises a trap request, the pointer keeps its value and the register write of that cycle is not committed.
- R8: Out register k of window w and in register k of window (w-1) mod NWIN are the same physical register.
- R9: trap_entry_i moves the pointer to (CWP-1) mod NWIN without checking the mask and never raises a request.
- R10: A privileged write loads the pointer with priv_cwp_i mod NWIN and the mask with the low NWIN bits of priv_wim_i. Mask bits at positions NWIN and above always read as zero.
- R11: The read ports return the value held before the clock edge, even when the same cycle writes that register. The new value can be read from the next cycle on.
- R12: After reset, the pointer is 0, the mask is 0 and every register reads as zero.
- R13: When several commands arrive in the same cycle, the privileged write wins first, then trap entry, then save, then restore. A command that loses causes no action and no trap request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs1_i | input | 5 | Architectural register number for read port 1 |
| rs2_i | input | 5 | Architectural register number for read port 2 |
| rdata1_o | output | XLEN | Read data from port 1, combinational |
| rdata2_o | output | XLEN | Read data from port 2, combinational |
| we_i | input | 1 | Write enable |
| wa_i | input | 5 | Architectural register number to write |
| wdata_i | input | XLEN | Write data |
| save_i | input | 1 | Save command: move the window pointer down |
| restore_i | input | 1 | Restore command: move the window pointer up |
| trap_entry_i | input | 1 | Trap entry: move the pointer down without checking the mask |
| priv_we_i | input | 1 | Privileged load of the pointer and the mask |
| priv_cwp_i | input | 5 | Pointer value to load |
| priv_wim_i | input | 32 | Mask value to load |
| cwp_o | output | 5 | Current window pointer, zero-extended |
| wim_o | output | 32 | Window invalid mask, zero-extended |
| ovf_req_o | output | 1 | Window overflow trap request |
| unf_req_o | output | 1 | Window underflow trap request |

## Verification
Results fall due at two different times. Read data and the two trap requests are combinational in the current pointer, the mask and the inputs, so they are due in the same cycle as the stimulus. The pointer, the mask and committed writes take effect at the next rising edge and are visible from the cycle after it. The bench drives inputs just after a falling edge and samples the combinational results 2 ns later, before the rising edge. It compares them with a model that is still in its pre-edge state. It then advances the model across the edge and checks cwp_o and wim_o at the following falling edge.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned ARCH_W = 5;
  localparam int unsigned NGLOB  = 8;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

  function automatic reg_grp_e grp_of(input logic [ARCH_W-1:0] arch);
    return reg_grp_e'(arch[4:3]);
  endfunction
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = $clog2(NWIN),
  parameter int unsigned PW   = $clog2(NGLOB + 16 * NWIN)
) (
  input  logic [CW-1:0]     cwp_i,
  input  logic [ARCH_W-1:0] arch_i,
  output logic [PW-1:0]     phys_o
);
  logic [CW-1:0] win;
  logic          upper_half;   // 0: locals, 1: ins of the window
  logic          is_global;

  always_comb begin
    win        = cwp_i;
    upper_half = 1'b0;
    is_global  = 1'b0;
    unique case (grp_of(arch_i))
      GRP_GLOBAL: is_global = 1'b1;
      GRP_OUT: begin
        // outs alias the ins of the window one below
        win        = cwp_i - CW'(1);
        upper_half = 1'b1;
      end
      GRP_LOCAL: upper_half = 1'b0;
      GRP_IN:    upper_half = 1'b1;
      default:   is_global  = 1'b1;
    endcase
  end

  always_comb begin
    if (is_global) phys_o = PW'(arch_i[2:0]);
    else           phys_o = PW'(NGLOB) + PW'({win, upper_half, arch_i[2:0]});
  end
endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = $clog2(NWIN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            trap_entry_i,
  input  logic            priv_we_i,
  input  logic [CW-1:0]   priv_cwp_i,
  input  logic [NWIN-1:0] priv_wim_i,
  output logic [CW-1:0]   cwp_o,
  output logic [NWIN-1:0] wim_o,
  output logic            ovf_o,
  output logic            unf_o
);
  logic [CW-1:0] cwp_q, cwp_dec, cwp_inc;
  logic [NWIN-1:0] wim_q;
  logic          save_sel, restore_sel;

  assign cwp_dec = cwp_q - CW'(1);
  assign cwp_inc = cwp_q + CW'(1);

  // priority: privileged load > trap entry > save > restore
  assign save_sel    = save_i & ~priv_we_i & ~trap_entry_i;
  assign restore_sel = restore_i & ~save_i & ~priv_we_i & ~trap_entry_i;

  assign ovf_o = save_sel & wim_q[cwp_dec];
  assign unf_o = restore_sel & wim_q[cwp_inc];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      wim_q <= '0;
    end else if (priv_we_i) begin
      cwp_q <= priv_cwp_i;
      wim_q <= priv_wim_i;
    end else if (trap_entry_i) begin
      cwp_q <= cwp_dec;
    end else if (save_sel && !ovf_o) begin
      cwp_q <= cwp_dec;
    end else if (restore_sel && !unf_o) begin
      cwp_q <= cwp_inc;
    end
  end

  assign cwp_o = cwp_q;
  assign wim_o = wim_q;
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int unsigned NPHYS = 136,
  parameter int unsigned PW    = 8,
  parameter int unsigned XLEN  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic [PW-1:0]   ra1_i,
  input  logic [PW-1:0]   ra2_i,
  output logic [XLEN-1:0] rd1_o,
  output logic [XLEN-1:0] rd2_o
);
  logic [XLEN-1:0] mem_q [NPHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NPHYS); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  // reads see pre-edge contents
  assign rd1_o = mem_q[ra1_i];
  assign rd2_o = mem_q[ra2_i];
endmodule

// File: rtl/wrf_top.sv
module wrf_top
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4:0]      rs1_i,
  input  logic [4:0]      rs2_i,
  output logic [XLEN-1:0] rdata1_o,
  output logic [XLEN-1:0] rdata2_o,
  input  logic            we_i,
  input  logic [4:0]      wa_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            trap_entry_i,
  input  logic            priv_we_i,
  input  logic [4:0]      priv_cwp_i,
  input  logic [31:0]     priv_wim_i,
  output logic [4:0]      cwp_o,
  output logic [31:0]     wim_o,
  output logic            ovf_req_o,
  output logic            unf_req_o
);
  localparam int unsigned CW    = $clog2(NWIN);
  localparam int unsigned NPHYS = NGLOB + 16 * NWIN;
  localparam int unsigned PW    = $clog2(NPHYS);

  logic [CW-1:0]   cwp;
  logic [NWIN-1:0] wim;
  logic            ovf, unf, wr_en;
  logic [PW-1:0]   pa_r1, pa_r2, pa_w;
  logic [XLEN-1:0] raw1, raw2;

  wrf_window_ctl #(.NWIN(NWIN), .CW(CW)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .save_i       (save_i),
    .restore_i    (restore_i),
    .trap_entry_i (trap_entry_i),
    .priv_we_i    (priv_we_i),
    .priv_cwp_i   (priv_cwp_i[CW-1:0]),
    .priv_wim_i   (priv_wim_i[NWIN-1:0]),
    .cwp_o        (cwp),
    .wim_o        (wim),
    .ovf_o        (ovf),
    .unf_o        (unf)
  );

  wrf_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map_r1 (
    .cwp_i (cwp), .arch_i (rs1_i), .phys_o (pa_r1)
  );
  wrf_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map_r2 (
    .cwp_i (cwp), .arch_i (rs2_i), .phys_o (pa_r2)
  );
  wrf_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map_w (
    .cwp_i (cwp), .arch_i (wa_i), .phys_o (pa_w)
  );

  // r0 is never stored; trapping save/restore drops the write
  assign wr_en = we_i & (wa_i != '0) & ~ovf & ~unf;

  wrf_storage #(.NPHYS(NPHYS), .PW(PW), .XLEN(XLEN)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .wa_i   (pa_w),
    .wd_i   (wdata_i),
    .ra1_i  (pa_r1),
    .ra2_i  (pa_r2),
    .rd1_o  (raw1),
    .rd2_o  (raw2)
  );

  assign rdata1_o  = (rs1_i == '0) ? '0 : raw1;
  assign rdata2_o  = (rs2_i == '0) ? '0 : raw2;
  assign cwp_o     = 5'(cwp);
  assign wim_o     = 32'(wim);
  assign ovf_req_o = ovf;
  assign unf_req_o = unf;

  generate
    if (CW < 5) begin : g_cwp_pad
      logic unused_cwp_hi;
      assign unused_cwp_hi = ^priv_cwp_i[4:CW];
    end
    if (NWIN < 32) begin : g_wim_pad
      logic unused_wim_hi;
      assign unused_wim_hi = ^priv_wim_i[31:NWIN];
    end
  endgenerate
endmodule

// File: rtl/wrf_checks.sv
module wrf_checks #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [4:0]      rs1_i,
  input logic [4:0]      rs2_i,
  input logic [XLEN-1:0] rdata1_o,
  input logic [XLEN-1:0] rdata2_o,
  input logic            save_i,
  input logic            restore_i,
  input logic            trap_entry_i,
  input logic            priv_we_i,
  input logic [4:0]      cwp_o,
  input logic [31:0]     wim_o,
  input logic            ovf_req_o,
  input logic            unf_req_o
);
  a_r2_zero_port1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs1_i == 5'd0 |-> rdata1_o == '0);
  a_r2_zero_port2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs2_i == 5'd0 |-> rdata2_o == '0);

  a_r3_save_steps_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !priv_we_i && !trap_entry_i && !ovf_req_o)
    |=> int'(cwp_o) == (int'($past(cwp_o)) + int'(NWIN) - 1) % int'(NWIN));

  a_r4_restore_steps_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !priv_we_i && !trap_entry_i && !unf_req_o)
    |=> int'(cwp_o) == (int'($past(cwp_o)) + 1) % int'(NWIN));

  a_r5_ovf_only_on_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_req_o |-> save_i && !priv_we_i && !trap_entry_i);

  a_r6_unf_only_on_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_req_o |-> restore_i && !save_i && !priv_we_i && !trap_entry_i);

  a_r6_single_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_req_o, unf_req_o}));

  a_r7_trap_holds_cwp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_req_o || unf_req_o) |=> $stable(cwp_o));

  a_r9_trap_entry_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_entry_i && !priv_we_i)
    |=> int'(cwp_o) == (int'($past(cwp_o)) + int'(NWIN) - 1) % int'(NWIN));

  a_r10_wim_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wim_o >> NWIN) == 32'd0);

  a_r10_cwp_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cwp_o) < int'(NWIN));
endmodule

bind wrf_top wrf_checks #(.NWIN(NWIN), .XLEN(XLEN)) u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rs1_i        (rs1_i),
  .rs2_i        (rs2_i),
  .rdata1_o     (rdata1_o),
  .rdata2_o     (rdata2_o),
  .save_i       (save_i),
  .restore_i    (restore_i),
  .trap_entry_i (trap_entry_i),
  .priv_we_i    (priv_we_i),
  .cwp_o        (cwp_o),
  .wim_o        (wim_o),
  .ovf_req_o    (ovf_req_o),
  .unf_req_o    (unf_req_o)
);

// File: tb/wrf_top_test.sv
`timescale 1ns/1ps
module wrf_top_test;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rs1 = '0, rs2 = '0, wa = '0, pc = '0;
  logic        we = 0, sv = 0, rsto = 0, te = 0, pw = 0;
  logic [31:0] wd = '0, pm = '0;
  logic [31:0] rd1, rd2, wim;
  logic [4:0]  cwp;
  logic        ovf, unf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wrf_top #(.NWIN(NW), .XLEN(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rs1_i(rs1), .rs2_i(rs2),
    .rdata1_o(rd1), .rdata2_o(rd2), .we_i(we), .wa_i(wa), .wdata_i(wd),
    .save_i(sv), .restore_i(rsto), .trap_entry_i(te), .priv_we_i(pw),
    .priv_cwp_i(pc), .priv_wim_i(pm), .cwp_o(cwp), .wim_o(wim),
    .ovf_req_o(ovf), .unf_req_o(unf)
  );

  // architectural model: outs of w live in ins of w-1
  logic [31:0] m_g   [8];
  logic [31:0] m_loc [NW][8];
  logic [31:0] m_in  [NW][8];
  int          m_cwp;
  logic [31:0] m_wim;

  function automatic logic [31:0] m_read(input int w, input logic [4:0] r);
    if (r == 0) return '0;
    if (r < 8)  return m_g[r];
    if (r < 16) return m_in[(w + NW - 1) % NW][r - 8];
    if (r < 24) return m_loc[w][r - 16];
    return m_in[w][r - 24];
  endfunction

  task automatic m_write(input int w, input logic [4:0] r, input logic [31:0] v);
    if (r == 0) return;
    if (r < 8)       m_g[r] = v;
    else if (r < 16) m_in[(w + NW - 1) % NW][r - 8] = v;
    else if (r < 24) m_loc[w][r - 16] = v;
    else             m_in[w][r - 24] = v;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_ovf();
    return sv && !pw && !te && m_wim[(m_cwp + NW - 1) % NW];
  endfunction
  function automatic logic exp_unf();
    return rsto && !sv && !pw && !te && m_wim[(m_cwp + 1) % NW];
  endfunction

  // drive after negedge; check comb results, step model over the edge, check state
  task automatic tick();
    logic eo, eu;
    int nc;
    logic [31:0] nw;
    #2;
    chk("R1 read port 1", rd1, m_read(m_cwp, rs1));
    chk("R1 read port 2", rd2, m_read(m_cwp, rs2));
    eo = exp_ovf();
    eu = exp_unf();
    chk("R5 overflow request", ovf, eo);
    chk("R6 underflow request", unf, eu);
    nc = m_cwp;
    nw = m_wim;
    if (pw) begin
      nc = int'(pc) % NW;
      nw = pm & ((32'd1 << NW) - 1);
    end else if (te) nc = (m_cwp + NW - 1) % NW;
    else if (sv && !eo) nc = (m_cwp + NW - 1) % NW;
    else if (rsto && !sv && !eu) nc = (m_cwp + 1) % NW;
    if (we && !eo && !eu) m_write(m_cwp, wa, wd);
    @(posedge clk);
    m_cwp = nc;
    m_wim = nw;
    @(negedge clk);
    chk("R3 window pointer", cwp, m_cwp);
    chk("R10 invalid mask", wim, m_wim);
  endtask

  task automatic idle();
    we = 0; sv = 0; rsto = 0; te = 0; pw = 0; wa = '0; wd = '0;
  endtask

  task automatic priv(input logic [4:0] c, input logic [31:0] m);
    idle(); pw = 1; pc = c; pm = m; tick(); idle();
  endtask

  task automatic wr(input logic [4:0] r, input logic [31:0] v);
    idle(); we = 1; wa = r; wd = v; tick(); idle();
  endtask

  initial begin
    #500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) m_g[i] = '0;
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 8; k++) begin m_loc[w][k] = '0; m_in[w][k] = '0; end
    m_cwp = 0; m_wim = '0;

    // R12 reset state
    rs1 = 5'd5; rs2 = 5'd20;
    #12;
    chk("R12 cwp after reset", cwp, 0);
    chk("R12 mask after reset", wim, 0);
    chk("R12 register after reset", rd1, 0);
    chk("R12 register after reset port 2", rd2, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R2 writes to r0 discarded
    wr(5'd0, 32'hDEAD_BEEF);
    rs1 = 5'd0; rs2 = 5'd0; #1;
    chk("R2 r0 reads zero", rd1, 0);
    chk("R2 r0 reads zero port 2", rd2, 0);

    // R1 globals shared, locals private
    wr(5'd3, 32'h0000_0333);
    wr(5'd17, 32'h0000_1717);
    idle(); sv = 1; tick(); idle();
    chk("R3 save wraps 0 to NWIN-1", cwp, 7);
    rs1 = 5'd3; rs2 = 5'd17; #1;
    chk("R1 global seen from new window", rd1, 32'h333);
    chk("R1 locals private per window", rd2, 0);

    // R8 outs of window 7 appear as ins of window 6
    wr(5'd10, 32'h0A0A_0A0A);
    idle(); sv = 1; tick(); idle();
    rs1 = 5'd26; #1;
    chk("R8 out becomes in after save", rd1, 32'h0A0A_0A0A);

    // R11 read during write returns old value
    wr(5'd20, 32'h0000_00AA);
    idle(); we = 1; wa = 5'd20; wd = 32'h0000_00BB; rs1 = 5'd20; #1;
    chk("R11 same-cycle read old value", rd1, 32'hAA);
    tick(); idle(); rs1 = 5'd20; #1;
    chk("R11 new value next cycle", rd1, 32'hBB);

    // R10 privileged load: cwp mod NWIN, mask upper bits zero
    priv(5'd13, 32'hFFFF_FFFF);
    chk("R10 cwp load modulo", cwp, 5);
    chk("R10 mask upper bits zero", wim, 32'h0000_00FF);

    // R9 trap entry ignores mask
    idle(); te = 1; #1;
    chk("R9 no request on trap entry", {ovf, unf}, 0);
    tick(); idle();
    chk("R9 trap entry moves down", cwp, 4);

    // R5 / R7 overflow: pointer held, write dropped
    priv(5'd4, 32'h0000_0008);
    wr(5'd18, 32'h1111_1111);
    idle(); sv = 1; we = 1; wa = 5'd18; wd = 32'h2222_2222; #1;
    chk("R5 overflow raised", ovf, 1);
    tick(); idle();
    chk("R7 cwp held on overflow", cwp, 4);
    rs1 = 5'd18; #1;
    chk("R7 write dropped on overflow", rd1, 32'h1111_1111);

    // R6 / R7 underflow
    priv(5'd4, 32'h0000_0020);
    idle(); rsto = 1; we = 1; wa = 5'd18; wd = 32'h3333_3333; #1;
    chk("R6 underflow raised", unf, 1);
    tick(); idle();
    chk("R7 cwp held on underflow", cwp, 4);
    rs1 = 5'd18; #1;
    chk("R7 write dropped on underflow", rd1, 32'h1111_1111);

    // R13 priority: trap entry beats save beats restore
    priv(5'd4, 32'h0000_0008);
    idle(); te = 1; sv = 1; rsto = 1; #1;
    chk("R13 trap entry suppresses overflow", ovf, 0);
    tick(); idle();
    chk("R13 trap entry wins", cwp, 3);
    priv(5'd2, 32'h0);
    idle(); sv = 1; rsto = 1; tick(); idle();
    chk("R13 save beats restore", cwp, 1);
    idle(); pw = 1; pc = 5'd6; pm = 32'h0; sv = 1; tick(); idle();
    chk("R13 privileged load wins", cwp, 6);

    // R4 wrap NWIN-1 -> 0
    priv(5'd7, 32'h0);
    idle(); rsto = 1; tick(); idle();
    chk("R4 restore wraps to 0", cwp, 0);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      idle();
      r = int'($urandom_range(0, 99));
      rs1 = 5'($urandom); rs2 = 5'($urandom);
      we = 1'($urandom); wa = 5'($urandom); wd = $urandom;
      if (r < 30) sv = 1;
      else if (r < 60) rsto = 1;
      else if (r < 63) te = 1;
      else if (r < 68) begin
        pw = 1; pc = 5'($urandom);
        pm = ($urandom_range(0, 3) == 0) ? $urandom : (32'd1 << $urandom_range(0, NW - 1));
      end else if (r < 72) begin sv = 1; rsto = 1; end
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule